// File: doc/BRIEF.md
# Rectangle Copy and Fill Blitter

The blitter runs one rectangle operation at a time over a linear, byte-addressed frame buffer. Its configuration (operation code, per-axis direction flags, pixel format code, source and destination coordinates, width, height, pitches, base offsets and three colours) is presented on input ports. All of it is captured on the cycle a start pulse is accepted. The engine first validates the request. It then either copies a source rectangle to a destination one byte at a time through a read-then-write memory port, or fills the destination with a single colour.

Each direction flag turns the programmed coordinate into either the near or the far edge of the rectangle. With the vertical flag clear, rows run from the last row to the first, so a copy that moves a region downward over itself does not overwrite source bytes before it reads them. When an operation ends, the engine reports a status code and, on success, the updated destination coordinates that software would store back.

Top module: `rect_blitter`

## Requirements
- R1: The pixel size comes from `fmt_code`: 2 gives 1 byte, 3 or 4 give 2 bytes, 5 gives 3 bytes, 6 gives 4 bytes. Any other code ends the operation with status 1 and no memory write.
- R2: With `x_ascend`=1 the start x is the programmed x, otherwise it is x+1-width (16-bit wrap). y follows the same rule with `y_ascend` and the height. Source coordinates use the same rule during a copy.
- R3: With `sep_regs`=1 the engine uses the separate source and destination pitch and base. With `sep_regs`=0 it uses `shared_pitch` and `shared_base` for both.
- R4: A rectangle is rejected with status 2 and no write when any of these holds: its pitch is zero, its start x or start y is above 0x3FFF, its base is at or past FB_BYTES, or it is non-empty and base+(y+h-1)*pitch+(x+w)*bytes exceeds FB_BYTES. The destination is checked before the operation code. The source is checked only for a copy, and after the code.
- R5: Supported `rop_code` values are 0xCC (copy), 0xF0 (fill with `brush_color`), 0x00 (fill with `black_color`) and 0xFF (fill with `white_color`). Any other value ends with status 3 and no write.
- R6: A copy moves one byte per two cycles. A read is issued at source address base+y*pitch+x*bytes+byte, and in the next cycle the returned byte is written to the matching destination address.
- R7: A copy runs rows first-to-last when `y_ascend`=1 and last-to-first otherwise. Bytes within a row run ascending when `x_ascend`=1 and descending otherwise.
- R8: A fill writes one byte per cycle, rows ascending and bytes ascending. Each pixel takes the low bytes of the colour in little-endian order (3 bytes at 24 bpp).
- R9: After a successful copy, the written-back x is start x+width if `x_ascend`, else start x. The written-back y is start y+height if `y_ascend`, else start y.
- R10: After a successful fill, the written-back y follows the R9 rule and the written-back x equals the programmed `dst_x`.
- R11: `busy` rises the cycle after an accepted start and stays high through the `done` cycle. A start while busy is ignored, and inputs are not sampled again until the next operation.
- R12: `done` is a one-cycle pulse carrying `status` (0 = success). `wb_valid` is high on it only on success. A zero width or height succeeds with no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted when idle |
| rop_code | input | 8 | Operation code |
| fmt_code | input | 4 | Pixel format code |
| x_ascend | input | 1 | 1: x is the left edge, 0: x is the right edge |
| y_ascend | input | 1 | 1: y is the top edge, 0: y is the bottom edge |
| sep_regs | input | 1 | 1: separate source/destination pitch and base, 0: shared |
| src_x | input | CW | Source x |
| src_y | input | CW | Source y |
| dst_x | input | CW | Destination x |
| dst_y | input | CW | Destination y |
| rect_w | input | CW | Width in pixels |
| rect_h | input | CW | Height in rows |
| src_pitch | input | PW | Source row pitch in bytes |
| dst_pitch | input | PW | Destination row pitch in bytes |
| shared_pitch | input | PW | Shared row pitch in bytes |
| src_base | input | AW | Source base byte offset |
| dst_base | input | AW | Destination base byte offset |
| shared_base | input | AW | Shared base byte offset |
| brush_color | input | 32 | Pattern fill colour |
| black_color | input | 32 | Black fill colour |
| white_color | input | 32 | White fill colour |
| mem_addr | output | AW | Byte address |
| mem_re | output | 1 | Read strobe, data returns next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | End-of-operation pulse |
| status | output | 2 | 0 ok, 1 bad format, 2 rejected, 3 unsupported code |
| wb_valid | output | 1 | Write-back values valid |
| wb_dst_x | output | CW | New destination x |
| wb_dst_y | output | CW | New destination y |

## Verification
A wrong row or byte counter in this block shows up as a wrong address or byte on `mem_addr`/`mem_wdata` in the same cycle as the write. The scoreboard compares each write against the model's next expected write, so the first divergent byte is caught. A wrong start-corner or validation decision appears at the `done` pulse a few cycles after start, as a wrong `status`, as write-back coordinates that differ from the model, or as writes where none were due. A full frame-buffer comparison after each operation catches any stray write that slipped past the per-write comparison.

// File: rtl/rect_blitter.sv
`timescale 1ns/1ps
module rect_blitter #(
  parameter int AW       = 12,
  parameter int FB_BYTES = 4096,
  parameter int CW       = 16,
  parameter int PW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    rop_code,
  input  logic [3:0]    fmt_code,
  input  logic          x_ascend,
  input  logic          y_ascend,
  input  logic          sep_regs,
  input  logic [CW-1:0] src_x,
  input  logic [CW-1:0] src_y,
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  input  logic [CW-1:0] rect_w,
  input  logic [CW-1:0] rect_h,
  input  logic [PW-1:0] src_pitch,
  input  logic [PW-1:0] dst_pitch,
  input  logic [PW-1:0] shared_pitch,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [AW-1:0] shared_base,
  input  logic [31:0]   brush_color,
  input  logic [31:0]   black_color,
  input  logic [31:0]   white_color,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [1:0]    status,
  output logic          wb_valid,
  output logic [CW-1:0] wb_dst_x,
  output logic [CW-1:0] wb_dst_y
);
  localparam int LW = AW + CW + PW + 4;
  localparam int BW = CW + 3;
  localparam logic [1:0] ST_OK = 2'd0, ST_FMT = 2'd1, ST_REJ = 2'd2, ST_UNIMP = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_READ, S_WRITE, S_FILL, S_DONE} state_t;
  state_t st;

  logic [7:0]    l_rop;
  logic [3:0]    l_fmt;
  logic          l_xasc, l_yasc, l_sep;
  logic [CW-1:0] l_sx, l_sy, l_dx, l_dy, l_w, l_h;
  logic [PW-1:0] l_sp, l_dp, l_shp;
  logic [AW-1:0] l_sb, l_db, l_shb;
  logic [31:0]   l_col;

  logic [CW-1:0] rcnt;
  logic [BW-1:0] bcnt;
  logic [1:0]    pb;

  function automatic logic rect_bad(input logic [AW-1:0] base, input logic [PW-1:0] pitch,
                                    input logic [CW-1:0] x, input logic [CW-1:0] y,
                                    input logic [CW-1:0] w, input logic [CW-1:0] h,
                                    input logic [2:0] bp);
    logic [LW-1:0] last;
    last = LW'(base) + (LW'(y) + LW'(h) - LW'(1)) * LW'(pitch) + (LW'(x) + LW'(w)) * LW'(bp);
    rect_bad = (pitch == '0) || (LW'(x) > LW'(16383)) || (LW'(y) > LW'(16383)) ||
               (LW'(base) >= LW'(FB_BYTES)) ||
               ((w != '0) && (h != '0) && (last > LW'(FB_BYTES)));
  endfunction

  logic [2:0] bypp;
  always_comb begin
    case (l_fmt)
      4'd2:       bypp = 3'd1;
      4'd3, 4'd4: bypp = 3'd2;
      4'd5:       bypp = 3'd3;
      4'd6:       bypp = 3'd4;
      default:    bypp = 3'd0;
    endcase
  end

  logic [CW-1:0] dsx, dsy, ssx, ssy;
  assign dsx = l_xasc ? l_dx : l_dx + CW'(1) - l_w;
  assign dsy = l_yasc ? l_dy : l_dy + CW'(1) - l_h;
  assign ssx = l_xasc ? l_sx : l_sx + CW'(1) - l_w;
  assign ssy = l_yasc ? l_sy : l_sy + CW'(1) - l_h;

  logic [PW-1:0] dpitch, spitch;
  logic [AW-1:0] dbase, sbase;
  assign dpitch = l_sep ? l_dp : l_shp;
  assign spitch = l_sep ? l_sp : l_shp;
  assign dbase  = l_sep ? l_db : l_shb;
  assign sbase  = l_sep ? l_sb : l_shb;

  logic is_copy, rop_ok, empty, dst_bad, src_bad;
  assign is_copy = (l_rop == 8'hCC);
  assign rop_ok  = is_copy || (l_rop == 8'hF0) || (l_rop == 8'h00) || (l_rop == 8'hFF);
  assign empty   = (l_w == '0) || (l_h == '0);
  assign dst_bad = rect_bad(dbase, dpitch, dsx, dsy, l_w, l_h, bypp);
  assign src_bad = rect_bad(sbase, spitch, ssx, ssy, l_w, l_h, bypp);

  logic [BW-1:0] rowbytes;
  assign rowbytes = BW'(l_w) * BW'(bypp);

  logic          fwd_rows, fwd_bytes;
  logic [CW-1:0] r_idx;
  logic [BW-1:0] b_idx;
  assign fwd_rows  = (st == S_FILL) || l_yasc;
  assign fwd_bytes = (st == S_FILL) || l_xasc;
  assign r_idx = fwd_rows  ? rcnt : l_h - CW'(1) - rcnt;
  assign b_idx = fwd_bytes ? bcnt : rowbytes - BW'(1) - bcnt;

  logic [AW-1:0] src_addr, dst_addr;
  assign src_addr = AW'(LW'(sbase) + (LW'(ssy) + LW'(r_idx)) * LW'(spitch) +
                        LW'(ssx) * LW'(bypp) + LW'(b_idx));
  assign dst_addr = AW'(LW'(dbase) + (LW'(dsy) + LW'(r_idx)) * LW'(dpitch) +
                        LW'(dsx) * LW'(bypp) + LW'(b_idx));

  logic last_byte, last_row;
  assign last_byte = (bcnt == rowbytes - BW'(1));
  assign last_row  = (rcnt == l_h - CW'(1));

  logic [7:0] fill_byte;
  assign fill_byte = l_col[{pb, 3'b000} +: 8];

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign wb_valid  = done && (status == ST_OK);
  assign mem_re    = (st == S_READ);
  assign mem_we    = (st == S_WRITE) || (st == S_FILL);
  assign mem_addr  = (st == S_READ) ? src_addr : dst_addr;
  assign mem_wdata = (st == S_FILL) ? fill_byte : mem_rdata;

  always_ff @(posedge clk) begin
    if (st == S_IDLE && start) begin
      l_rop  <= rop_code;
      l_fmt  <= fmt_code;
      l_xasc <= x_ascend;
      l_yasc <= y_ascend;
      l_sep  <= sep_regs;
      l_sx   <= src_x;
      l_sy   <= src_y;
      l_dx   <= dst_x;
      l_dy   <= dst_y;
      l_w    <= rect_w;
      l_h    <= rect_h;
      l_sp   <= src_pitch;
      l_dp   <= dst_pitch;
      l_shp  <= shared_pitch;
      l_sb   <= src_base;
      l_db   <= dst_base;
      l_shb  <= shared_base;
      l_col  <= (rop_code == 8'hF0) ? brush_color :
                (rop_code == 8'h00) ? black_color : white_color;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      status   <= ST_OK;
      wb_dst_x <= '0;
      wb_dst_y <= '0;
      rcnt     <= '0;
      bcnt     <= '0;
      pb       <= '0;
    end else begin
      case (st)
        S_IDLE:  if (start) st <= S_CHECK;
        S_CHECK: begin
          rcnt <= '0;
          bcnt <= '0;
          pb   <= '0;
          st   <= S_DONE;
          if (bypp == 3'd0)           status <= ST_FMT;
          else if (dst_bad)           status <= ST_REJ;
          else if (!rop_ok)           status <= ST_UNIMP;
          else if (is_copy && src_bad) status <= ST_REJ;
          else begin
            status   <= ST_OK;
            wb_dst_x <= is_copy ? (l_xasc ? dsx + l_w : dsx) : l_dx;
            wb_dst_y <= l_yasc ? dsy + l_h : dsy;
            if (!empty) st <= is_copy ? S_READ : S_FILL;
          end
        end
        S_READ:  st <= S_WRITE;
        S_WRITE, S_FILL: begin
          if (last_byte) begin
            bcnt <= '0;
            pb   <= '0;
            if (last_row) st <= S_DONE;
            else begin
              rcnt <= rcnt + CW'(1);
              st   <= (st == S_WRITE) ? S_READ : S_FILL;
            end
          end else begin
            bcnt <= bcnt + BW'(1);
            pb   <= (pb == 2'(bypp - 3'd1)) ? 2'd0 : pb + 2'd1;
            st   <= (st == S_WRITE) ? S_READ : S_FILL;
          end
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic wrote;
  always_ff @(posedge clk) begin
    if (!rst_n)              wrote <= 1'b0;
    else if (st == S_CHECK)  wrote <= 1'b0;
    else if (mem_we)         wrote <= 1'b1;
  end

  // R1, R4, R5: a refused operation leaves memory untouched
  a_r4_refused_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status != ST_OK) |-> !wrote);

  a_r6_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (mem_we && !mem_re));

  a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re));

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
endmodule

// File: tb/rect_blitter_tb.sv
`timescale 1ns/1ps
module rect_blitter_tb;
  localparam int FB = 4096;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0]  rop_code = 8'h00;
  logic [3:0]  fmt_code = 4'd6;
  logic        x_ascend = 1'b1, y_ascend = 1'b1, sep_regs = 1'b1;
  logic [15:0] src_x = '0, src_y = '0, dst_x = '0, dst_y = '0, rect_w = '0, rect_h = '0;
  logic [15:0] src_pitch = '0, dst_pitch = '0, shared_pitch = '0;
  logic [11:0] src_base = '0, dst_base = '0, shared_base = '0;
  logic [31:0] brush_color = '0, black_color = '0, white_color = '0;
  logic [11:0] mem_addr;
  logic        mem_re, mem_we, busy, done, wb_valid;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [1:0]  status;
  logic [15:0] wb_dst_x, wb_dst_y;

  int tests = 0, fails = 0;
  logic [7:0] fbmem [FB];
  logic [7:0] shadow [FB];
  int exp_q [$];
  string cur_tag = "";

  always #10 clk = ~clk;

  rect_blitter u_dut (.*);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < FB; i++) fbmem[i] <= 8'(i * 37 + 11);
      mem_rdata <= '0;
    end else begin
      if (mem_re) mem_rdata <= fbmem[mem_addr];
      if (mem_we) fbmem[mem_addr] <= mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_tag, what, act, expv);
    end
  endtask

  // monitor: each design write is popped against the model's queue
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) chk(1'b0, "unexpected write", {mem_addr, mem_wdata}, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(e == int'({mem_addr, mem_wdata}), "write addr/data", {mem_addr, mem_wdata}, e);
      end
    end
  end

  function automatic int bytes_of(input int f);
    case (f)
      2: return 1;
      3, 4: return 2;
      5: return 3;
      6: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic bit refused(input int base, input int p, input int x, input int y,
                                 input int w, input int h, input int bp);
    longint last;
    if (p == 0 || x > 16383 || y > 16383 || base >= FB) return 1;
    if (w == 0 || h == 0) return 0;
    last = longint'(base) + longint'(y + h - 1) * p + longint'(x + w) * bp;
    return last > FB;
  endfunction

  task automatic do_op(input string tag, input bit poke);
    int bp, w, h, dsx, dsy, ssx, ssy, dp, sp, db, sb, st, rop, ex, ey, cnt;
    bit copy;
    logic [31:0] col;
    cur_tag = tag;
    bp = bytes_of(int'(fmt_code));
    w = int'(rect_w); h = int'(rect_h);
    dsx = x_ascend ? int'(dst_x) : (int'(dst_x) + 1 - w) & 16'hFFFF;
    dsy = y_ascend ? int'(dst_y) : (int'(dst_y) + 1 - h) & 16'hFFFF;
    ssx = x_ascend ? int'(src_x) : (int'(src_x) + 1 - w) & 16'hFFFF;
    ssy = y_ascend ? int'(src_y) : (int'(src_y) + 1 - h) & 16'hFFFF;
    dp = sep_regs ? int'(dst_pitch) : int'(shared_pitch);
    sp = sep_regs ? int'(src_pitch) : int'(shared_pitch);
    db = sep_regs ? int'(dst_base) : int'(shared_base);
    sb = sep_regs ? int'(src_base) : int'(shared_base);
    rop = int'(rop_code);
    copy = (rop == 'hCC);
    if (bp == 0) st = 1;
    else if (refused(db, dp, dsx, dsy, w, h, bp)) st = 2;
    else if (!(copy || rop == 'hF0 || rop == 'h00 || rop == 'hFF)) st = 3;
    else if (copy && refused(sb, sp, ssx, ssy, w, h, bp)) st = 2;
    else st = 0;
    col = (rop == 'hF0) ? brush_color : (rop == 'h00) ? black_color : white_color;
    if (st == 0 && w > 0 && h > 0) begin
      if (copy) begin
        for (int rr = 0; rr < h; rr++) begin
          int r;
          r = y_ascend ? rr : h - 1 - rr;
          for (int bb = 0; bb < w * bp; bb++) begin
            int b, sa, da;
            b  = x_ascend ? bb : w * bp - 1 - bb;
            sa = sb + (ssy + r) * sp + ssx * bp + b;
            da = db + (dsy + r) * dp + dsx * bp + b;
            shadow[da] = shadow[sa];
            exp_q.push_back((da << 8) | int'(shadow[da]));
          end
        end
      end else begin
        for (int r = 0; r < h; r++)
          for (int b = 0; b < w * bp; b++) begin
            int da;
            logic [7:0] d;
            da = db + (dsy + r) * dp + dsx * bp + b;
            d = 8'(col >> (8 * (b % bp)));
            shadow[da] = d;
            exp_q.push_back((da << 8) | int'(d));
          end
      end
    end
    ex = copy ? (x_ascend ? (dsx + w) & 16'hFFFF : dsx) : int'(dst_x);
    ey = y_ascend ? (dsy + h) & 16'hFFFF : dsy;

    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11 busy after start", busy, 1);
    cnt = 0;
    while (!done && cnt < 20000) begin
      cnt++;
      if (poke && cnt == 3) begin
        dst_x = dst_x + 16'd5;
        rop_code = 8'hFF;
        start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(done == 1'b1, "R12 done seen (watchdog)", done, 1);
    chk(int'(status) == st, "R12 status", status, st);
    chk(wb_valid == (st == 0), "R12 wb_valid", wb_valid, st == 0);
    if (st == 0) begin
      chk(int'(wb_dst_x) == ex, "R9/R10 wb x", wb_dst_x, ex);
      chk(int'(wb_dst_y) == ey, "R9/R10 wb y", wb_dst_y, ey);
    end
    @(negedge clk);
    chk(!done && !busy, "R12 done one cycle", {done, busy}, 0);
    if (poke) begin
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        chk(!done && !busy && !mem_we, "R11 ignored start left no trace", {done, busy, mem_we}, 0);
      end
    end
    chk(exp_q.size() == 0, "missing writes", exp_q.size(), 0);
    exp_q.delete();
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < FB; i++) if (fbmem[i] !== shadow[i]) bad++;
      chk(bad == 0, "frame buffer image", bad, 0);
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < FB; i++) shadow[i] = 8'(i * 37 + 11);
    brush_color = 32'hA1B2C3D4;
    black_color = 32'h00102030;
    white_color = 32'h00F0E0D0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_tag = "reset";
    chk(!busy && !done && !mem_we && !mem_re, "R11 reset idle", {busy, done, mem_we, mem_re}, 0);

    // R8 R10: 32 bpp pattern fill, ascending
    rop_code = 8'hF0; fmt_code = 4'd6; x_ascend = 1; y_ascend = 1; sep_regs = 1;
    dst_x = 2; dst_y = 3; rect_w = 3; rect_h = 2; dst_pitch = 64; dst_base = 256;
    do_op("R8 R10 R1 fill32", 0);

    // R2 R8 R10: 24 bpp black fill, far-edge coordinates
    rop_code = 8'h00; fmt_code = 4'd5; x_ascend = 0; y_ascend = 0;
    dst_x = 10; dst_y = 8; rect_w = 4; rect_h = 3; dst_pitch = 48; dst_base = 1024;
    do_op("R2 R8 R10 fill24", 0);

    // R3: 8 bpp white fill through the shared pitch/base (dst pitch zero)
    rop_code = 8'hFF; fmt_code = 4'd2; x_ascend = 1; y_ascend = 1; sep_regs = 0;
    dst_pitch = 0; shared_pitch = 32; shared_base = 2048;
    dst_x = 1; dst_y = 1; rect_w = 5; rect_h = 2;
    do_op("R3 R5 fill8 shared", 0);

    // R6 R9: 16 bpp copy, separate regions
    rop_code = 8'hCC; fmt_code = 4'd3; sep_regs = 1;
    src_base = 0; src_pitch = 40; src_x = 1; src_y = 1;
    dst_base = 3000; dst_pitch = 40; dst_x = 2; dst_y = 2; rect_w = 4; rect_h = 3;
    do_op("R6 R9 copy16", 0);

    // R7 R2 R9: overlapping downward copy, far edges, shared regs
    fmt_code = 4'd4; x_ascend = 0; y_ascend = 0; sep_regs = 0;
    shared_base = 512; shared_pitch = 32;
    src_x = 5; src_y = 5; dst_x = 6; dst_y = 6; rect_w = 4; rect_h = 4;
    do_op("R7 R2 R9 overlap copy", 0);

    // R11: start pulses while busy are ignored
    fmt_code = 4'd6; x_ascend = 1; y_ascend = 1; sep_regs = 1;
    src_base = 0; src_pitch = 64; src_x = 0; src_y = 0;
    dst_base = 2560; dst_pitch = 64; dst_x = 0; dst_y = 0; rect_w = 8; rect_h = 2;
    do_op("R11 busy copy32", 1);

    // R1: unknown format code
    rop_code = 8'hF0; fmt_code = 4'd7; dst_pitch = 64; dst_base = 256; dst_x = 0; dst_y = 0;
    rect_w = 2; rect_h = 2;
    do_op("R1 bad format", 0);

    // R5: unsupported operation code
    fmt_code = 4'd2; rop_code = 8'h55;
    do_op("R5 unsupported code", 0);

    // R4: destination checked before the code
    dst_pitch = 0;
    do_op("R4 R5 zero pitch priority", 0);

    // R4: zero pitch on a fill
    rop_code = 8'hF0;
    do_op("R4 zero pitch", 0);

    // R4: start x above limit after far-edge wrap
    dst_pitch = 64; x_ascend = 0; dst_x = 1; rect_w = 5;
    do_op("R4 x limit", 0);

    // R4: last row past the end of memory
    x_ascend = 1; dst_x = 0; rect_w = 2; rect_h = 4; dst_base = 4000;
    do_op("R4 bounds dst", 0);

    // R4: source bounds on a copy
    rop_code = 8'hCC; dst_base = 256; src_base = 4000; src_pitch = 64;
    do_op("R4 bounds src", 0);

    // R12: empty rectangle succeeds with no writes
    rop_code = 8'hF0; rect_w = 0; rect_h = 2; dst_y = 7;
    do_op("R12 R10 empty", 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule